// File: doc/BRIEF.md
# Asynchronous SRAM Controller

This block gives a clocked user port read and write access to an external asynchronous static RAM of 128K bytes. A request is accepted when the block is idle. It drives the address and the three active-low strobes (chip enable, write enable, output enable). The bidirectional data bus is split into an output value, an input value and a drive enable, which a pad ring combines. Each strobe edge belongs to its own state, and every interval is a parameter given as a number of clock cycles: address setup, access time, write pulse width and read-to-write bus turnaround.

A transaction runs through these states: idle, address setup with all strobes high, then either an access window (read) or a write pulse. A read ends with a turnaround gap. A write ends with a one-cycle hold in which write enable is high again and the data is still driven. Read data is registered when the access count expires, and a single-cycle done pulse is raised in the same cycle. A write raises its done pulse once the hold cycle is over.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset, chip enable, write enable and output enable are all high, the data drive enable is low and done is low.
- R2: Only three strobe combinations ever appear, given as (ce_n, we_n, oe_n): standby (1,1,1), read (0,1,0) and write (0,0,1). Output enable is never low during a write.
- R3: The memory address changes only in a cycle where chip enable and write enable are high and were also high in the cycle before. After a change, the address is held for at least SETUP_CYC cycles before chip enable falls.
- R4: A read keeps chip enable and output enable low for exactly ACC_CYC cycles. The memory byte present at the end of that window appears on rdata_o in the cycle done_o is high. done_o rises SETUP_CYC+ACC_CYC cycles after the accepting clock edge.
- R5: A write keeps write enable low for exactly WP_CYC cycles, with the data driven for the whole pulse and for one more cycle after write enable rises. done_o rises SETUP_CYC+WP_CYC+1 cycles after the accepting edge.
- R6: The data drive enable is asserted only while output enable is high and was high in the cycle before. After a read, output enable stays high for at least TURN_CYC+1 cycles before the bus is driven.
- R7: While a transaction is in progress, req_i, we_i, addr_i and wdata_i are ignored. No extra transaction, and no write to a changed address, results from them.
- R8: When req_i is held high, requests are served in the order presented. The next one is accepted TURN_CYC+1 cycles after a read's done pulse, or 1 cycle after a write's done pulse.
- R9: done_o is high for one cycle per transaction and never in two consecutive cycles.
- R10: rdata_o changes only together with the done pulse of a read, and it keeps its value across writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Transaction request, sampled only when idle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 17 | Word address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Last read data |
| done_o | output | 1 | One-cycle completion pulse |
| mem_addr_o | output | 17 | Memory address lines |
| mem_ce_no | output | 1 | Memory chip enable, active low |
| mem_we_no | output | 1 | Memory write enable, active low |
| mem_oe_no | output | 1 | Memory output enable, active low |
| mem_dq_o | output | 8 | Data bus value to drive |
| mem_dq_i | input | 8 | Data bus value received |
| mem_dq_oe_o | output | 1 | Data bus drive enable |

## Verification
If the request is first sampled at edge c, a read's done and data are due in the cycle after edge c+SETUP_CYC+ACC_CYC. A write's done is due after edge c+SETUP_CYC+WP_CYC+1. The next held request is accepted TURN_CYC+1 or 1 cycles after a done. The driver computes each due cycle from these counts and queues it, and the monitor compares the cycle number at every done pulse with the queued value. The bench memory model presents valid read data only after ACC_CYC cycles with the strobes low, so a capture made too early returns a wrong byte. The model also measures strobe widths, address age and bus-drive gaps one cycle at a time, away from the clock edge.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_RD_ACC,
    ST_RD_TURN,
    ST_WR_PULSE,
    ST_WR_HOLD
  } ctrl_state_e;
endpackage

// File: rtl/sram_interval_cnt.sv
module sram_interval_cnt #(
  parameter int CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (load_i)           cnt_q <= load_val_i;
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

  // counter saturates at zero so an idle wait never wraps
  AST_CNT_SATURATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && expired_o) |=> expired_o); // R4
endmodule

// File: rtl/sram_pin_drive.sv
module sram_pin_drive
  import sram_ctrl_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  ctrl_state_e state_nxt_i,
  output logic        ce_no,
  output logic        we_no,
  output logic        oe_no,
  output logic        dq_oe_o
);
  // registered pins: decoded from next state, so no decode glitches reach the bus
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_no   <= 1'b1;
      we_no   <= 1'b1;
      oe_no   <= 1'b1;
      dq_oe_o <= 1'b0;
    end else begin
      ce_no   <= !(state_nxt_i == ST_RD_ACC || state_nxt_i == ST_WR_PULSE);
      we_no   <= !(state_nxt_i == ST_WR_PULSE);
      oe_no   <= !(state_nxt_i == ST_RD_ACC);
      dq_oe_o <= (state_nxt_i == ST_WR_PULSE) || (state_nxt_i == ST_WR_HOLD);
    end
  end

  AST_WE_NEEDS_CE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_no |-> !ce_no); // R2
  AST_OE_OFF_IN_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_no |-> (we_no && !ce_no)); // R2
  AST_NO_BUS_FIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> (oe_no && $past(oe_no))); // R6
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W    = 17,
  parameter int DATA_W    = 8,
  parameter int SETUP_CYC = 1,
  parameter int ACC_CYC   = 2,
  parameter int WP_CYC    = 2,
  parameter int TURN_CYC  = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_ce_no,
  output logic              mem_we_no,
  output logic              mem_oe_no,
  output logic [DATA_W-1:0] mem_dq_o,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic              mem_dq_oe_o
);
  localparam int MAX_SA  = (SETUP_CYC > ACC_CYC) ? SETUP_CYC : ACC_CYC;
  localparam int MAX_WT  = (WP_CYC > TURN_CYC) ? WP_CYC : TURN_CYC;
  localparam int MAX_CYC = (MAX_SA > MAX_WT) ? MAX_SA : MAX_WT;
  localparam int CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);
  localparam int WLO_W   = $clog2(WP_CYC + 2);

  ctrl_state_e      state_q, state_d;
  logic             cnt_load, cnt_expired;
  logic [CNT_W-1:0] cnt_val;
  logic             accept, capture, done_d;
  logic             op_wr_q;

  initial begin
    if (SETUP_CYC < 1 || ACC_CYC < 1 || WP_CYC < 1 || TURN_CYC < 1)
      $error("sram_async_ctrl: every cycle count must be at least 1");
  end

  sram_interval_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (cnt_load),
    .load_val_i (cnt_val),
    .expired_o  (cnt_expired)
  );

  always_comb begin
    state_d  = state_q;
    cnt_load = 1'b0;
    cnt_val  = '0;
    accept   = 1'b0;
    capture  = 1'b0;
    done_d   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_i) begin
        accept   = 1'b1;
        state_d  = ST_SETUP;
        cnt_load = 1'b1;
        cnt_val  = CNT_W'(SETUP_CYC - 1);
      end
      ST_SETUP: if (cnt_expired) begin
        cnt_load = 1'b1;
        if (op_wr_q) begin
          state_d = ST_WR_PULSE;
          cnt_val = CNT_W'(WP_CYC - 1);
        end else begin
          state_d = ST_RD_ACC;
          cnt_val = CNT_W'(ACC_CYC - 1);
        end
      end
      ST_RD_ACC: if (cnt_expired) begin
        capture  = 1'b1;
        done_d   = 1'b1;
        state_d  = ST_RD_TURN;
        cnt_load = 1'b1;
        cnt_val  = CNT_W'(TURN_CYC - 1);
      end
      ST_RD_TURN: if (cnt_expired) state_d = ST_IDLE;
      ST_WR_PULSE: if (cnt_expired) begin
        state_d  = ST_WR_HOLD;
        cnt_load = 1'b1;
      end
      ST_WR_HOLD: begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      op_wr_q    <= 1'b0;
      mem_addr_o <= '0;
      mem_dq_o   <= '0;
      rdata_o    <= '0;
      done_o     <= 1'b0;
    end else begin
      state_q <= state_d;
      done_o  <= done_d;
      if (accept) begin
        op_wr_q    <= we_i;
        mem_addr_o <= addr_i;
        mem_dq_o   <= wdata_i;
      end
      if (capture) rdata_o <= mem_dq_i;
    end
  end

  sram_pin_drive u_pins (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .state_nxt_i (state_d),
    .ce_no       (mem_ce_no),
    .we_no       (mem_we_no),
    .oe_no       (mem_oe_no),
    .dq_oe_o     (mem_dq_oe_o)
  );

  // write-pulse width tracker for the assertion below
  logic [WLO_W-1:0] we_lo_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         we_lo_cnt <= '0;
    else if (!mem_we_no) we_lo_cnt <= we_lo_cnt + 1'b1;
    else                 we_lo_cnt <= '0;
  end

  AST_ADDR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mem_addr_o) |-> (mem_ce_no && mem_we_no && $past(mem_ce_no) && $past(mem_we_no))); // R3
  AST_WP_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_no) |-> (we_lo_cnt == WLO_W'(WP_CYC))); // R5
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rdata_o) |-> (done_o && !$past(mem_oe_no))); // R10
endmodule

// File: tb/sram_async_ctrl_bench.sv
`timescale 1ns/1ps
module sram_async_ctrl_bench;
  localparam int S = 2;
  localparam int A = 3;
  localparam int W = 2;
  localparam int T = 2;

  typedef struct {
    bit          wr;
    logic [16:0] addr;
    logic [7:0]  data;
  } item_t;

  typedef struct {
    bit          wr;
    logic [16:0] addr;
    logic [7:0]  data;
    int          due;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [16:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        done;
  logic [16:0] mem_addr;
  logic        ce_n, we_n, oe_n, dq_oe;
  logic [7:0]  dq_out;
  logic [7:0]  dq_in = '0;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  item_t plan[$];
  exp_t  sb[$];
  logic [7:0] mem_m [int];
  logic [7:0] shadow [int];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sram_async_ctrl #(
    .SETUP_CYC(S), .ACC_CYC(A), .WP_CYC(W), .TURN_CYC(T)
  ) u_sram_async_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .done_o(done), .mem_addr_o(mem_addr),
    .mem_ce_no(ce_n), .mem_we_no(we_n), .mem_oe_no(oe_n), .mem_dq_o(dq_out),
    .mem_dq_i(dq_in), .mem_dq_oe_o(dq_oe)
  );

  function automatic logic [7:0] dflt(logic [16:0] a);
    return a[7:0] ^ 8'h5A;
  endfunction

  task automatic chk(bit ok, string req_tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", req_tag, act, exp, cyc);
    end
  endtask

  // ---------------- memory model ----------------
  bit          m_init = 0;
  logic [16:0] p_addr;
  logic [7:0]  p_dq;
  logic        p_ce, p_we, p_oe, p_dqoe;
  int          rd_cnt = 0, we_cnt = 0, oe_len = 0, addr_age = 0, oe_hi_age = 100;

  always @(negedge clk) begin
    if (rst_ni) begin
      if (m_init) begin
        if ({ce_n, we_n, oe_n} != {p_ce, p_we, p_oe})
          chk(({ce_n, we_n, oe_n} == 3'b111) || ({ce_n, we_n, oe_n} == 3'b010) ||
              ({ce_n, we_n, oe_n} == 3'b001), "R2", {ce_n, we_n, oe_n}, 3'b111);
        if (mem_addr != p_addr) begin
          chk(ce_n && we_n && p_ce && p_we, "R3", {ce_n, we_n, p_ce, p_we}, 4'hF);
          addr_age = 0;
        end else addr_age++;
        if (!ce_n && p_ce) chk(addr_age >= S, "R3", addr_age, S);
        // write pulse ends: commit and check width / hold
        if (we_n && !p_we) begin
          chk(we_cnt == W, "R5", we_cnt, W);
          chk(dq_oe && p_dqoe, "R5", {dq_oe, p_dqoe}, 2'b11);
          mem_m[int'(p_addr)] = p_dq;
          we_cnt = 0;
        end
        if (!we_n) begin
          we_cnt++;
          chk(dq_oe, "R5", dq_oe, 1);
        end
        if (oe_n && !p_oe) begin
          chk(oe_len == A, "R4", oe_len, A);
          oe_len = 0;
        end
        if (!oe_n) oe_len++;
        if (oe_n) oe_hi_age++; else oe_hi_age = 0;
        if (dq_oe && !p_dqoe) chk(oe_hi_age >= T + 1, "R6", oe_hi_age, T + 1);
        if (dq_oe) chk(oe_n, "R6", oe_n, 1);
      end
      if (!ce_n && !oe_n && we_n) rd_cnt++; else rd_cnt = 0;
      if (rd_cnt >= A)
        dq_in = mem_m.exists(int'(mem_addr)) ? mem_m[int'(mem_addr)] : dflt(mem_addr);
      else
        dq_in = 8'h00;
      p_addr = mem_addr; p_dq = dq_out;
      p_ce = ce_n; p_we = we_n; p_oe = oe_n; p_dqoe = dq_oe;
      m_init = 1;
    end
  end

  // ---------------- monitor ----------------
  logic       p_done = 0;
  logic [7:0] last_rd = '0;
  always @(negedge clk) begin
    if (rst_ni) begin
      if (done && p_done) chk(0, "R9", 1, 0);
      if (done) begin
        if (sb.size() == 0) chk(0, "R8", 1, 0);
        else begin
          exp_t e;
          e = sb.pop_front();
          if (e.wr) begin
            chk(cyc == e.due, "R5", cyc, e.due);
            chk(mem_m.exists(int'(e.addr)) && mem_m[int'(e.addr)] == e.data, "R5",
                mem_m.exists(int'(e.addr)) ? mem_m[int'(e.addr)] : 0, e.data);
            chk(rdata == last_rd, "R10", rdata, last_rd);
          end else begin
            chk(cyc == e.due, "R4", cyc, e.due);
            chk(rdata == e.data, "R4", rdata, e.data);
            last_rd = e.data;
          end
        end
      end
      p_done = done;
    end
  end

  // ---------------- driver ----------------
  task automatic drive_all();
    int acc = 0;
    bit prev_wr = 0;
    for (int i = 0; i < plan.size(); i++) begin
      item_t it;
      exp_t  e;
      it = plan[i];
      we = it.wr; addr = it.addr; wdata = it.data; req = 1'b1;
      if (i == 0) acc = cyc + 1;
      else        acc = cyc + (prev_wr ? 1 : T + 1); // R8
      e.wr = it.wr; e.addr = it.addr;
      if (it.wr) begin
        shadow[int'(it.addr)] = it.data;
        e.data = it.data;
      end else
        e.data = shadow.exists(int'(it.addr)) ? shadow[int'(it.addr)] : dflt(it.addr);
      e.due = acc + S + (it.wr ? W + 1 : A);
      sb.push_back(e);
      while (cyc < acc) @(negedge clk);
      // R7: scramble every input while busy
      we = ~it.wr; addr = ~it.addr; wdata = ~it.data;
      do @(negedge clk); while (!done);
      prev_wr = it.wr;
    end
    req = 1'b0;
    plan.delete();
  endtask

  task automatic report();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    report();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({ce_n, we_n, oe_n, dq_oe, done} == 5'b11100, "R1", {ce_n, we_n, oe_n, dq_oe, done}, 5'b11100);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk({ce_n, we_n, oe_n, dq_oe, done} == 5'b11100, "R1", {ce_n, we_n, oe_n, dq_oe, done}, 5'b11100);
    chk(rdata == 8'h00, "R1", rdata, 0);

    // single write then single read
    plan.push_back('{1, 17'h00010, 8'hA5});
    drive_all();
    repeat (5) @(negedge clk);
    plan.push_back('{0, 17'h00010, 8'h00});
    drive_all();
    repeat (5) @(negedge clk);

    // back-to-back mix with held request, address extremes
    plan.push_back('{1, 17'h1FFFF, 8'h3C});
    plan.push_back('{1, 17'h00000, 8'hC3});
    plan.push_back('{0, 17'h1FFFF, 8'h00});
    plan.push_back('{0, 17'h00000, 8'h00});
    plan.push_back('{1, 17'h12345, 8'h7E});
    plan.push_back('{0, 17'h12345, 8'h00});
    plan.push_back('{0, 17'h0ABCD, 8'h00});
    plan.push_back('{1, 17'h0ABCD, 8'h81});
    plan.push_back('{0, 17'h0ABCD, 8'h00});
    plan.push_back('{1, 17'h00010, 8'h11});
    plan.push_back('{1, 17'h00010, 8'hEE});
    plan.push_back('{0, 17'h00010, 8'h00});
    drive_all();
    repeat (10) @(negedge clk);

    chk(sb.size() == 0, "R8", sb.size(), 0);
    chk(mem_m.num() == shadow.num(), "R7", mem_m.num(), shadow.num());
    chk({ce_n, we_n, oe_n, dq_oe} == 4'b1110, "R2", {ce_n, we_n, oe_n, dq_oe}, 4'b1110);
    report();
    $finish;
  end
endmodule